// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a small register placed between two clouds of combinational logic. A two-bit mode input selects what it does on each rising clock edge. It can capture its parallel inputs like an ordinary pipeline register. It can shift serially as one link in a scan chain. It can clear itself. It can also act as a linear-feedback self-test engine.

In the self-test mode, parallel data is XOR-folded into the feedback. With the data held at zero, the register produces a maximal-length pseudo-random pattern of period seven. With a response stream applied, it compresses that stream into a signature. A self-test run scans in a nonzero seed, lets the register generate or compact data, and then scans the result out for comparison against a value computed off-chip.

Top module: `bilbo_reg`

## Requirements
- R1: With mode 2'b11 (normal), each edge loads q <= d.
- R2: With mode 2'b00 (scan), each edge loads q[0] <= si and q[i] <= q[i-1] for i >= 1.
- R3: The serial output so equals q[2] at all times, so the bit about to leave the chain is visible before the shifting edge.
- R4: With mode 2'b10 (clear), the next edge makes q = 3'b000.
- R5: A high rst on an edge makes q = 3'b000 whatever the mode.
- R6: With mode 2'b01 (test), d = 0 and q = 3'b111, successive edges give q[2:0] = 011, 101, 010, 001, 100, 110, 111, which is a period of 7.
- R7: With mode 2'b01, each edge computes q[0] <= q[1]^d[0], q[1] <= q[2]^d[1], q[2] <= q[0]^q[2]^d[2]. As a result, a one-bit change anywhere in a response stream changes the final signature.
- R8: In test mode with d = 0, a nonzero state never steps to zero.
- R9: A new mode code applies at the first edge after it changes, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to zero, active high |
| mode | input | 2 | 00 scan, 01 test, 10 clear, 11 normal |
| d | input | 3 | Parallel data / response input |
| si | input | 1 | Serial scan input into bit 0 |
| q | output | 3 | Register contents |
| so | output | 1 | Serial output, equal to q[2] |

## Verification
The test mode is run first with all-zero data from the all-ones seed. Every state of the period-7 walk is compared, which tells a correct tap set apart from any other feedback. It is then run with a fixed nonzero response stream, and the final signature is compared with a model built from the R7 equations. This shows that data is folded into the correct bit positions. A second stream that differs from the first in one bit must produce a different signature, which confirms that compaction does not mask a single error. Scan, clear, reset and normal-capture rows are mixed in so that every mode change is seen to take effect on the first edge.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
    typedef enum logic [1:0] {
        MODE_SCAN   = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_CLEAR  = 2'b10,
        MODE_NORMAL = 2'b11
    } bilbo_mode_e;
endpackage

// File: rtl/bilbo_shift.sv
// Serial scan step: the serial input enters the low bit and the rest move up.
module bilbo_shift #(
    parameter int W = 3
) (
    input  logic [W-1:0] cur,
    input  logic         si,
    output logic [W-1:0] nxt
);
    assign nxt = {cur[W-2:0], si};
endmodule

// File: rtl/bilbo_misr.sv
// Linear-feedback step with parallel data folded into every stage.
module bilbo_misr #(
    parameter int           W    = 3,
    parameter logic [W-1:0] TAPS = 3'b101
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt
);
    for (genvar i = 0; i < W - 1; i++) begin : g_stage
        assign nxt[i] = cur[i+1] ^ din[i];
    end
    assign nxt[W-1] = (^(cur & TAPS)) ^ din[W-1];
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int           W    = 3,
    parameter logic [W-1:0] TAPS = 3'b101
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic [W-1:0] d,
    input  logic         si,
    output logic [W-1:0] q,
    output logic         so
);
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t      st_d, st_q;
    bilbo_mode_e mode_e;
    logic [W-1:0] shift_nxt, misr_nxt;

    assign mode_e = bilbo_mode_e'(mode);

    bilbo_shift #(.W(W)) i_shift (
        .cur (st_q.bits),
        .si  (si),
        .nxt (shift_nxt)
    );

    bilbo_misr #(.W(W), .TAPS(TAPS)) i_misr (
        .cur (st_q.bits),
        .din (d),
        .nxt (misr_nxt)
    );

    always_comb begin
        st_d = st_q;
        unique case (mode_e)
            MODE_SCAN:   st_d.bits = shift_nxt;
            MODE_TEST:   st_d.bits = misr_nxt;
            MODE_CLEAR:  st_d.bits = ZERO;
            MODE_NORMAL: st_d.bits = d;
            default:     st_d.bits = ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q  = st_q.bits;
    assign so = st_q.bits[W-1];

    AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> (q == $past(d)));                              // R1
    AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (q == {$past(q[W-2:0]), $past(si)}));          // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q == ZERO));                                  // R4
    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && d == ZERO && q != ZERO) |=> (q != ZERO));        // R8
endmodule

// File: tb/test_bilbo_reg.sv
module test_bilbo_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b11;
    logic [2:0] d = 3'b000;
    logic       si = 1'b0;
    logic [2:0] q;
    logic       so;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bilbo_reg i_bilbo_reg (
        .clk(clk), .rst(rst), .mode(mode), .d(d), .si(si), .q(q), .so(so)
    );

    // row: {mode[1:0], d[2:0], si, expected q[2:0]}
    localparam int NV = 16;
    localparam logic [8:0] VEC [NV] = '{
        {2'b11, 3'b101, 1'b0, 3'b101},   // R1 capture
        {2'b11, 3'b011, 1'b0, 3'b011},   // R1, R9
        {2'b10, 3'b111, 1'b1, 3'b000},   // R4
        {2'b00, 3'b000, 1'b1, 3'b001},   // R2
        {2'b00, 3'b000, 1'b1, 3'b011},   // R2
        {2'b00, 3'b000, 1'b1, 3'b111},   // R2 seed
        {2'b01, 3'b000, 1'b0, 3'b011},   // R6
        {2'b01, 3'b000, 1'b0, 3'b101},   // R6
        {2'b01, 3'b000, 1'b0, 3'b010},   // R6
        {2'b01, 3'b000, 1'b0, 3'b001},   // R6
        {2'b01, 3'b000, 1'b0, 3'b100},   // R6
        {2'b01, 3'b000, 1'b0, 3'b110},   // R6
        {2'b01, 3'b000, 1'b0, 3'b111},   // R6 back to seed
        {2'b10, 3'b000, 1'b0, 3'b000},   // R4, R9
        {2'b01, 3'b000, 1'b0, 3'b000},   // R8 zero stays zero
        {2'b11, 3'b110, 1'b0, 3'b110}    // R1
    };

    localparam int NS = 8;
    localparam logic [2:0] STREAM [NS] = '{
        3'b101, 3'b011, 3'b000, 3'b110, 3'b001, 3'b111, 3'b010, 3'b100
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [2:0] dv, input logic s);
        mode = m; d = dv; si = s;
        @(negedge clk);
    endtask

    function automatic logic [2:0] model_step(input logic [2:0] c, input logic [2:0] x);
        model_step = {c[0] ^ c[2] ^ x[2], c[2] ^ x[1], c[1] ^ x[0]};
    endfunction

    task automatic seed_ones();
        step(2'b10, 3'b000, 1'b0);
        step(2'b00, 3'b000, 1'b1);
        step(2'b00, 3'b000, 1'b1);
        step(2'b00, 3'b000, 1'b1);
    endtask

    logic [2:0] good_sig, bad_sig, m;

    initial begin
        #160000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R5 reset state", q, 3'b000);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][8:7], VEC[k][6:4], VEC[k][3]);
            check($sformatf("R1/R2/R4/R6/R9 row %0d", k), q, VEC[k][2:0]);
            check("R3 so tracks q[2]", {2'b00, so}, {2'b00, q[2]});
        end

        // R7 signature of a fixed response stream
        seed_ones();
        m = 3'b111;
        for (int k = 0; k < NS; k++) begin
            step(2'b01, STREAM[k], 1'b0);
            m = model_step(m, STREAM[k]);
        end
        good_sig = q;
        check("R7 signature", q, m);

        // R7 one flipped bit changes the signature
        seed_ones();
        m = 3'b111;
        for (int k = 0; k < NS; k++) begin
            logic [2:0] x;
            x = (k == 3) ? (STREAM[k] ^ 3'b010) : STREAM[k];
            step(2'b01, x, 1'b0);
            m = model_step(m, x);
        end
        bad_sig = q;
        check("R7 flipped signature", bad_sig, m);
        check("R7 flip detected", {2'b00, bad_sig != good_sig}, 3'b001);

        // R2/R3 scan round trip
        step(2'b11, 3'b110, 1'b0);
        check("R3 so before shift 0", {2'b00, so}, 3'b001);
        step(2'b00, 3'b000, 1'b1);
        check("R3 so before shift 1", {2'b00, so}, 3'b001);
        step(2'b00, 3'b000, 1'b0);
        check("R3 so before shift 2", {2'b00, so}, 3'b000);
        step(2'b00, 3'b000, 1'b0);
        check("R2 scanned-in word", q, 3'b100);

        // R5 reset overrides every mode
        step(2'b11, 3'b111, 1'b0);
        rst = 1'b1;
        step(2'b11, 3'b111, 1'b1);
        check("R5 reset over normal", q, 3'b000);
        rst = 1'b0;
        seed_ones();
        rst = 1'b1;
        step(2'b01, 3'b000, 1'b0);
        check("R5 reset over test", q, 3'b000);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule